// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block turns the operand-addressing fields of a memory reference into an offset and a linear address. Each field is optional: a base register value, an index register value shifted left by a two-bit scale code, and a displacement that is either absent, a sign-extended byte, or a full 32-bit word. The three terms are added modulo 2^32. In 16-bit address mode only the low half of that sum is kept. A segment base is then added to give the linear address.

A request is presented with a one-cycle strobe. One clock later the block returns the offset, the linear address and a flag. The flag marks a request that names the stack-pointer register (register number 4) as its index. That encoding cannot be used, so the index term is dropped and the flag is raised. Instruction-byte decoding and segment limit checks are done elsewhere.

Top module: `scaled_ea_gen`

## Requirements
- R1: While `rst` is high, and until the first strobe after reset, `out_valid`, `eff_addr`, `lin_addr` and `bad_index` are all zero.
- R2: In 32-bit mode (`addr16`=0), `eff_addr` equals base + scaled index + displacement, wrapped modulo 2^32.
- R3: The index term is `index_val` shifted left by `scale_code`. Code 0 multiplies by 1, code 1 by 2, code 2 by 4 and code 3 by 8. Bits shifted out above bit 31 are lost.
- R4: `disp_kind` selects the displacement. 0 means no displacement. 1 means `disp_val[7:0]` sign-extended to 32 bits. 2 means all 32 bits of `disp_val`. 3 is treated as no displacement.
- R5: A base with `base_valid`=0 adds zero, and so does an index with `index_valid`=0. This gives a displacement-only (direct) form and a base-only (register-indirect) form.
- R6: When `index_valid`=1 and `index_num`=4, `bad_index` is 1 and the index term is zero. Any other index number, or an absent index, gives `bad_index`=0.
- R7: When `addr16`=1, `eff_addr[15:0]` is the low half of the sum and `eff_addr[31:16]` is zero.
- R8: `lin_addr` equals the segment base plus `eff_addr`, wrapped modulo 2^32. The segment base is the value of `seg_base` sampled with the request.
- R9: Outputs update, and `out_valid` is high for exactly one cycle, on the clock edge after the edge that samples `req_valid`=1. Without a strobe, `out_valid` is 0 and the other outputs keep their values whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, samples all request inputs |
| base_valid | input | 1 | Base term present |
| base_val | input | 32 | Base register value |
| index_valid | input | 1 | Index term present |
| index_num | input | 3 | Register number of the index |
| index_val | input | 32 | Index register value |
| scale_code | input | 2 | Index shift amount (0..3) |
| disp_kind | input | 2 | Displacement size code |
| disp_val | input | 32 | Displacement value |
| addr16 | input | 1 | 16-bit address mode |
| seg_base | input | 32 | Segment base address |
| out_valid | output | 1 | Result valid pulse |
| eff_addr | output | 32 | Effective address (offset) |
| lin_addr | output | 32 | Linear address |
| bad_index | output | 1 | Stack pointer named as index |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 3-bit register numbers, register 4 as the forbidden index, a 16-bit short mode and a byte-wide short displacement. With these values the bench can reach several cases directly:
- sums that wrap past 2^32;
- index shifts that push bits out of the top;
- byte displacements with the sign bit both set and clear;
- short-mode sums whose upper half must be cleared.

Random requests cover every value of `index_num`, so the forbidden index comes up often alongside valid ones.

// File: rtl/eag_pkg.sv
package eag_pkg;

    typedef enum logic [1:0] {
        DISP_NONE = 2'd0,
        DISP_BYTE = 2'd1,
        DISP_FULL = 2'd2,
        DISP_RSVD = 2'd3
    } disp_kind_e;

    typedef enum logic [1:0] {
        SCALE_X1 = 2'd0,
        SCALE_X2 = 2'd1,
        SCALE_X4 = 2'd2,
        SCALE_X8 = 2'd3
    } scale_e;

    function automatic int unsigned scale_shift(input scale_e s);
        case (s)
            SCALE_X2: return 1;
            SCALE_X4: return 2;
            SCALE_X8: return 3;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/eag_disp_ext.sv
module eag_disp_ext
    import eag_pkg::*;
#(
    parameter int AW     = 32,
    parameter int BYTE_W = 8
) (
    input  logic [1:0]    disp_kind,
    input  logic [AW-1:0] disp_val,
    output logic [AW-1:0] disp_ext
);
    localparam int PAD_W = AW - BYTE_W;

    disp_kind_e kind;
    assign kind = disp_kind_e'(disp_kind);

    always_comb begin
        case (kind)
            DISP_BYTE: disp_ext = {{PAD_W{disp_val[BYTE_W-1]}}, disp_val[BYTE_W-1:0]};
            DISP_FULL: disp_ext = disp_val;
            default:   disp_ext = '0;
        endcase
    end
endmodule

// File: rtl/eag_index_scale.sv
module eag_index_scale
    import eag_pkg::*;
#(
    parameter int AW     = 32,
    parameter int REG_W  = 3,
    parameter int SP_NUM = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             index_valid,
    input  logic [REG_W-1:0] index_num,
    input  logic [AW-1:0]    index_val,
    input  logic [1:0]       scale_code,
    output logic [AW-1:0]    index_term,
    output logic             illegal
);
    localparam logic [REG_W-1:0] SP_CODE = REG_W'(SP_NUM);

    logic use_index;

    assign illegal   = index_valid && (index_num == SP_CODE);
    assign use_index = index_valid && !illegal;

    always_comb begin
        if (use_index)
            index_term = index_val << scale_shift(scale_e'(scale_code));
        else
            index_term = '0;
    end

    AST_ILLEGAL_ZERO_TERM: assert property (@(posedge clk) disable iff (rst)
        (index_valid && index_num == SP_CODE) |-> (index_term == '0)); // R6
    AST_SHIFT_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
        (scale_code == 2'd3) |-> (index_term[2:0] == 3'b000)); // R3
    AST_ABSENT_INDEX: assert property (@(posedge clk) disable iff (rst)
        !index_valid |-> (index_term == '0 && !illegal)); // R5
endmodule

// File: rtl/eag_sum.sv
module eag_sum #(
    parameter int AW      = 32,
    parameter int SHORT_W = 16
) (
    input  logic          base_valid,
    input  logic [AW-1:0] base_val,
    input  logic [AW-1:0] index_term,
    input  logic [AW-1:0] disp_ext,
    input  logic          addr16,
    input  logic [AW-1:0] seg_base,
    output logic [AW-1:0] eff_next,
    output logic [AW-1:0] lin_next
);
    logic [AW-1:0] base_term;
    logic [AW-1:0] raw_sum;

    assign base_term = base_valid ? base_val : '0;
    assign raw_sum   = base_term + index_term + disp_ext;

    generate
        if (SHORT_W < AW) begin : g_trunc
            assign eff_next = addr16 ? {{(AW-SHORT_W){1'b0}}, raw_sum[SHORT_W-1:0]} : raw_sum;
        end else begin : g_full
            logic unused_mode;
            assign unused_mode = addr16;
            assign eff_next    = raw_sum;
        end
    endgenerate

    assign lin_next = seg_base + eff_next;
endmodule

// File: rtl/scaled_ea_gen.sv
module scaled_ea_gen
    import eag_pkg::*;
#(
    parameter int AW      = 32,
    parameter int REG_W   = 3,
    parameter int SP_NUM  = 4,
    parameter int SHORT_W = 16,
    parameter int BYTE_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             base_valid,
    input  logic [AW-1:0]    base_val,
    input  logic             index_valid,
    input  logic [REG_W-1:0] index_num,
    input  logic [AW-1:0]    index_val,
    input  logic [1:0]       scale_code,
    input  logic [1:0]       disp_kind,
    input  logic [AW-1:0]    disp_val,
    input  logic             addr16,
    input  logic [AW-1:0]    seg_base,
    output logic             out_valid,
    output logic [AW-1:0]    eff_addr,
    output logic [AW-1:0]    lin_addr,
    output logic             bad_index
);
    logic [AW-1:0] disp_ext;
    logic [AW-1:0] index_term;
    logic          illegal;
    logic [AW-1:0] eff_next;
    logic [AW-1:0] lin_next;

    eag_disp_ext #(.AW(AW), .BYTE_W(BYTE_W)) u_disp (
        .disp_kind (disp_kind),
        .disp_val  (disp_val),
        .disp_ext  (disp_ext)
    );

    eag_index_scale #(.AW(AW), .REG_W(REG_W), .SP_NUM(SP_NUM)) u_idx (
        .clk         (clk),
        .rst         (rst),
        .index_valid (index_valid),
        .index_num   (index_num),
        .index_val   (index_val),
        .scale_code  (scale_code),
        .index_term  (index_term),
        .illegal     (illegal)
    );

    eag_sum #(.AW(AW), .SHORT_W(SHORT_W)) u_sum (
        .base_valid (base_valid),
        .base_val   (base_val),
        .index_term (index_term),
        .disp_ext   (disp_ext),
        .addr16     (addr16),
        .seg_base   (seg_base),
        .eff_next   (eff_next),
        .lin_next   (lin_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            eff_addr  <= '0;
            lin_addr  <= '0;
            bad_index <= 1'b0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                eff_addr  <= eff_next;
                lin_addr  <= lin_next;
                bad_index <= illegal;
            end
        end
    end

    AST_STROBE_TO_VALID: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid); // R9
    AST_NO_STROBE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid); // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(eff_addr) && $stable(lin_addr))); // R9
    AST_SHORT_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (req_valid && addr16) |=> (eff_addr[AW-1:SHORT_W] == '0)); // R7
    AST_LINEAR_SUM: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (lin_addr == $past(seg_base) + eff_addr)); // R8
    AST_BYTE_SIGN: assert property (@(posedge clk) disable iff (rst)
        (disp_kind == 2'd1) |-> (disp_ext[AW-1] == disp_val[BYTE_W-1])); // R4
endmodule

// File: tb/scaled_ea_gen_tb.sv
module scaled_ea_gen_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        base_valid = 1'b0;
    logic [31:0] base_val = '0;
    logic        index_valid = 1'b0;
    logic [2:0]  index_num = '0;
    logic [31:0] index_val = '0;
    logic [1:0]  scale_code = '0;
    logic [1:0]  disp_kind = '0;
    logic [31:0] disp_val = '0;
    logic        addr16 = 1'b0;
    logic [31:0] seg_base = '0;
    logic        out_valid;
    logic [31:0] eff_addr;
    logic [31:0] lin_addr;
    logic        bad_index;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    scaled_ea_gen u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid),
        .base_valid(base_valid), .base_val(base_val),
        .index_valid(index_valid), .index_num(index_num), .index_val(index_val),
        .scale_code(scale_code), .disp_kind(disp_kind), .disp_val(disp_val),
        .addr16(addr16), .seg_base(seg_base),
        .out_valid(out_valid), .eff_addr(eff_addr), .lin_addr(lin_addr),
        .bad_index(bad_index)
    );

    function automatic logic [31:0] model_eff(
        input logic bv, input logic [31:0] b, input logic iv, input logic [2:0] inum,
        input logic [31:0] i, input logic [1:0] sc, input logic [1:0] dk,
        input logic [31:0] d, input logic a16);
        logic [31:0] s;
        logic [31:0] dx;
        s = bv ? b : 32'd0;
        if (iv && inum != 3'd4) s = s + (i * (32'd1 << sc));
        case (dk)
            2'd1: dx = 32'(signed'(d[7:0]));
            2'd2: dx = d;
            default: dx = 32'd0;
        endcase
        s = s + dx;
        if (a16) s = s & 32'h0000_FFFF;
        return s;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic bv, input logic [31:0] b, input logic iv,
                        input logic [2:0] inum, input logic [31:0] i, input logic [1:0] sc,
                        input logic [1:0] dk, input logic [31:0] d, input logic a16,
                        input logic [31:0] sb, input string req);
        logic [31:0] e;
        @(negedge clk);
        base_valid = bv; base_val = b; index_valid = iv; index_num = inum;
        index_val = i; scale_code = sc; disp_kind = dk; disp_val = d;
        addr16 = a16; seg_base = sb; req_valid = 1'b1;
        e = model_eff(bv, b, iv, inum, i, sc, dk, d, a16);
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " eff"}, eff_addr, e);
        check("R8 lin", lin_addr, sb + e);
        check("R6 bad", {31'd0, bad_index}, {31'd0, iv && inum == 3'd4});
        check("R9 valid", {31'd0, out_valid}, 32'd1);
    endtask

    initial begin
        logic [31:0] pe, pl;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", {31'd0, out_valid}, 32'd0);
        check("R1 eff", eff_addr, 32'd0);
        check("R1 lin", lin_addr, 32'd0);
        check("R1 bad", {31'd0, bad_index}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after", eff_addr | lin_addr, 32'd0);

        // R2 full combination with wrap
        send(1, 32'hFFFF_FFF0, 1, 3'd6, 32'h0000_0010, 2'd2, 2'd2, 32'h0000_0100, 0, 32'h1000_0000, "R2");
        // R3 each scale code, top bits shifted out
        for (int s = 0; s < 4; s++)
            send(0, 0, 1, 3'd1, 32'hF000_0003, 2'(s), 2'd0, 0, 0, 0, "R3");
        // R4 displacement kinds, byte sign set and clear
        send(1, 32'h100, 0, 0, 0, 0, 2'd1, 32'h1234_5680, 0, 0, "R4 neg byte");
        send(1, 32'h100, 0, 0, 0, 0, 2'd1, 32'hFFFF_FF7F, 0, 0, "R4 pos byte");
        send(1, 32'h100, 0, 0, 0, 0, 2'd3, 32'h5555_5555, 0, 0, "R4 code3");
        // R5 direct and register-indirect
        send(0, 32'hDEAD_BEEF, 0, 3'd2, 32'h1111, 2'd1, 2'd2, 32'h0000_0500, 0, 32'h20, "R5 direct");
        send(1, 32'h0000_4000, 0, 3'd2, 32'h1111, 2'd1, 2'd0, 32'h9999, 0, 32'h20, "R5 indirect");
        // R6 forbidden index, and register 4 as base is fine
        send(1, 32'h1000, 1, 3'd4, 32'h7777_7777, 2'd3, 2'd1, 32'h10, 0, 0, "R6 sp index");
        send(1, 32'h1000, 1, 3'd5, 32'h4, 2'd0, 2'd0, 0, 0, 0, "R6 other index");
        // R7 short mode
        send(1, 32'h0001_FFFF, 1, 3'd0, 32'h1, 2'd0, 2'd1, 32'h02, 1, 32'hABCD_0000, "R7");

        // R9 hold without strobe
        pe = eff_addr; pl = lin_addr;
        @(negedge clk);
        base_val = 32'h1234_5678; disp_kind = 2'd2; disp_val = 32'h77; seg_base = 32'h9;
        @(negedge clk);
        check("R9 hold valid", {31'd0, out_valid}, 32'd0);
        check("R9 hold eff", eff_addr, pe);
        check("R9 hold lin", lin_addr, pl);

        // random mix
        for (int k = 0; k < 400; k++)
            send($urandom_range(0, 1), $urandom, $urandom_range(0, 1), 3'($urandom_range(0, 7)),
                 $urandom, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), $urandom,
                 $urandom_range(0, 1), $urandom, "R2 random");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule